// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Compare

This block keeps wall-clock time in an always-on slow clock domain. One counter, advanced once per slow-clock cycle, holds the time. Its upper field counts whole seconds and its lower field holds the sub-second fraction, so the fraction carries into the seconds when it overflows. With the default 15-bit fraction and a 32.768 kHz clock, one count of the seconds field is one second. A small word-addressed register file lets software load the time, set an alarm, start and stop counting, read sticky status flags and choose which flags raise the interrupt line. Writes arrive already synchronised to the slow domain and take effect at the clock edge. Reads are combinational.

Counting is governed by a three-state machine. `CNT_UNSEEDED` is the state after reset, in which the counter never moves. A write to the seconds register takes it either to `CNT_RUNNING` (run bit already set) or to `CNT_HALTED` (run bit clear). From `CNT_HALTED` it goes to `CNT_RUNNING` when the run bit is set. From `CNT_RUNNING` it returns to `CNT_HALTED` when the run bit is cleared. There is no way back to `CNT_UNSEEDED` other than reset. An equality compare between the counter and the programmed alarm sets a sticky alarm flag. A violation event input sets a second sticky flag. A third flag, set at reset, tells software that the time has not been established yet.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: While counting, the counter rises by exactly one on each clock edge. The fraction carries into the seconds, and the whole counter wraps to zero after its all-ones value.
- R2: Control register (offset 0x10) bit 3 is the run bit. The state machine follows it one edge late, so a run bit written at edge E0 from the halted state gives increments at edges E0+2 onward. A clear written at edge Eb still allows the increment at Eb+1, and the counter then holds.
- R3: After reset the counter does not move, even with the run bit set, until the seconds register (offset 0x00) has been written. A fraction write before that only loads the fraction. A seconds write with the run bit set starts counting at the next edge.
- R4: A write to offset 0x00 replaces only the seconds field (low SEC_W data bits). A write to offset 0x04 replaces only the fraction field (low FRAC_W data bits). A write takes precedence over the increment in the same cycle, and the untouched field keeps its value without incrementing.
- R5: Status bit 4, the alarm flag, sets on the edge after the counter equals {alarm seconds at 0x08, alarm fraction at 0x0C}. It then stays set until cleared, even after the counter moves past the alarm value.
- R6: An alarm seconds value of all ones never matches. That value is the alarm seconds register's reset value.
- R7: Status flags at offset 0x14 are cleared by writing 1 to their bit positions, and a 0 bit leaves a flag unchanged. If a flag is cleared and set in the same cycle, it stays set.
- R8: Status bit 1, the not-valid flag, is 1 after reset and is only ever cleared. Status bit 0, the violation flag, sets on the edge after a one-cycle pulse on `sec_viol`.
- R9: `irq` is high whenever any status flag is set together with its enable bit at offset 0x18 (bits 4, 1 and 0).
- R10: After reset the registers read back as: time 0, alarm seconds all ones, alarm fraction 0, control 0, status 0x02, enable 0. Unused bits read zero, and an unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock; one cycle per counter step |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sec_viol | input | 1 | Violation event pulse; sets status bit 0 |
| irq | output | 1 | Interrupt request from enabled status flags |

## Verification
The alarm compare can set the alarm flag in the same cycle that software writes 1 to clear it. The bench provokes this by halting the counter exactly on the alarm value, so the compare holds on every edge, and then issuing the clear. Reading the status back must show the flag still set. Moving the alarm fraction one step away and clearing again must then leave the flag clear. A seconds write that lands on a counting edge is judged the same way, from the counter value read back once the counter has been halted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_TIME_SEC  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_TIME_FRAC = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_ALM_SEC   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_ALM_FRAC  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL      = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 5'h18;

    localparam int CTRL_RUN_BIT     = 3;
    localparam int FLAG_ALARM_BIT   = 4;
    localparam int FLAG_INVALID_BIT = 1;
    localparam int FLAG_VIOL_BIT    = 0;

    typedef enum logic [1:0] {
        CNT_UNSEEDED = 2'd0,
        CNT_HALTED   = 2'd1,
        CNT_RUNNING  = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic alarm;
        logic invalid;
        logic viol;
    } flags_t;

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int CNT_W = SEC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [SEC_W-1:0]  wr_sec,
    input  logic [FRAC_W-1:0] wr_frac,
    output logic [CNT_W-1:0]  count
);

    cnt_state_e state_q, state_d;
    logic       step;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_UNSEEDED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_UNSEEDED: if (ld_sec) state_d = run_en ? CNT_RUNNING : CNT_HALTED;
            CNT_HALTED:   if (run_en) state_d = CNT_RUNNING;
            CNT_RUNNING:  if (!run_en) state_d = CNT_HALTED;
            default:      state_d = CNT_UNSEEDED;
        endcase
    end

    // outputs of the machine
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            CNT_RUNNING: step = 1'b1;
            default:     step = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_sec || ld_frac) begin
            if (ld_sec)  count[CNT_W-1:FRAC_W] <= wr_sec;
            if (ld_frac) count[FRAC_W-1:0]     <= wr_frac;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CNT_RUNNING && !ld_sec && !ld_frac) |=> (count == $past(count) + 1'b1)); // R1
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CNT_HALTED && !ld_sec && !ld_frac) |=> $stable(count)); // R2
    AST_UNSEEDED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CNT_UNSEEDED && !ld_sec && !ld_frac) |=> $stable(count)); // R3
    AST_SEED_STICKS: assert property (@(posedge clk) disable iff (!rst_n) (state_q != CNT_UNSEEDED) |=> (state_q != CNT_UNSEEDED)); // R3

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int CNT_W = SEC_W + FRAC_W
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [SEC_W-1:0]  alm_sec,
    input  logic [FRAC_W-1:0] alm_frac,
    output logic              hit
);

    logic never;

    always_comb begin
        never = (alm_sec == {SEC_W{1'b1}});
        hit   = !never && (count == {alm_sec, alm_frac});
    end

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
    import rtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   alarm_hit,
    input  logic   viol_evt,
    input  logic   clr_we,
    input  flags_t clr_bits,
    input  flags_t irq_en,
    output flags_t flags,
    output logic   irq
);

    flags_t clr;

    always_comb begin
        clr = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags.alarm   <= 1'b0;
            flags.invalid <= 1'b1;
            flags.viol    <= 1'b0;
        end else begin
            flags.alarm   <= alarm_hit | (flags.alarm & ~clr.alarm);
            flags.invalid <= flags.invalid & ~clr.invalid;
            flags.viol    <= viol_evt | (flags.viol & ~clr.viol);
        end
    end

    assign irq = |(flags & irq_en);

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flags.alarm && !clr.alarm) |=> flags.alarm); // R5
    AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n) alarm_hit |=> flags.alarm); // R5
    AST_W1C_ALARM: assert property (@(posedge clk) disable iff (!rst_n) (clr.alarm && !alarm_hit) |=> !flags.alarm); // R7
    AST_VIOL_SETS: assert property (@(posedge clk) disable iff (!rst_n) viol_evt |=> flags.viol); // R8
    AST_INVALID_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !flags.invalid |=> !flags.invalid); // R8

endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              sec_viol,
    output logic              irq
);

    localparam int CNT_W = SEC_W + FRAC_W;

    logic [CNT_W-1:0]  cnt;
    logic [SEC_W-1:0]  alm_sec_q;
    logic [FRAC_W-1:0] alm_frac_q;
    logic              run_q;
    flags_t            irq_en_q;
    flags_t            st_flags;
    flags_t            wr_flags;
    logic              hit;
    logic              we_tsec, we_tfrac, we_asec, we_afrac, we_ctrl, we_stat, we_ien;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    always_comb begin
        we_tsec  = bus_we && (bus_addr == OFS_TIME_SEC);
        we_tfrac = bus_we && (bus_addr == OFS_TIME_FRAC);
        we_asec  = bus_we && (bus_addr == OFS_ALM_SEC);
        we_afrac = bus_we && (bus_addr == OFS_ALM_FRAC);
        we_ctrl  = bus_we && (bus_addr == OFS_CTRL);
        we_stat  = bus_we && (bus_addr == OFS_STATUS);
        we_ien   = bus_we && (bus_addr == OFS_IRQ_EN);
        wr_flags.alarm   = bus_wdata[FLAG_ALARM_BIT];
        wr_flags.invalid = bus_wdata[FLAG_INVALID_BIT];
        wr_flags.viol    = bus_wdata[FLAG_VIOL_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_sec_q  <= {SEC_W{1'b1}};
            alm_frac_q <= '0;
            run_q      <= 1'b0;
            irq_en_q   <= '0;
        end else begin
            if (we_asec)  alm_sec_q  <= bus_wdata[SEC_W-1:0];
            if (we_afrac) alm_frac_q <= bus_wdata[FRAC_W-1:0];
            if (we_ctrl)  run_q      <= bus_wdata[CTRL_RUN_BIT];
            if (we_ien)   irq_en_q   <= wr_flags;
        end
    end

    rtc_time_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_q),
        .ld_sec  (we_tsec),
        .ld_frac (we_tfrac),
        .wr_sec  (bus_wdata[SEC_W-1:0]),
        .wr_frac (bus_wdata[FRAC_W-1:0]),
        .count   (cnt)
    );

    rtc_alarm_cmp #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cmp (
        .count    (cnt),
        .alm_sec  (alm_sec_q),
        .alm_frac (alm_frac_q),
        .hit      (hit)
    );

    rtc_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_hit (hit),
        .viol_evt  (sec_viol),
        .clr_we    (we_stat),
        .clr_bits  (wr_flags),
        .irq_en    (irq_en_q),
        .flags     (st_flags),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TIME_SEC:  bus_rdata = BUS_W'(cnt[CNT_W-1:FRAC_W]);
            OFS_TIME_FRAC: bus_rdata = BUS_W'(cnt[FRAC_W-1:0]);
            OFS_ALM_SEC:   bus_rdata = BUS_W'(alm_sec_q);
            OFS_ALM_FRAC:  bus_rdata = BUS_W'(alm_frac_q);
            OFS_CTRL:      bus_rdata[CTRL_RUN_BIT] = run_q;
            OFS_STATUS: begin
                bus_rdata[FLAG_ALARM_BIT]   = st_flags.alarm;
                bus_rdata[FLAG_INVALID_BIT] = st_flags.invalid;
                bus_rdata[FLAG_VIOL_BIT]    = st_flags.viol;
            end
            OFS_IRQ_EN: begin
                bus_rdata[FLAG_ALARM_BIT]   = irq_en_q.alarm;
                bus_rdata[FLAG_INVALID_BIT] = irq_en_q.invalid;
                bus_rdata[FLAG_VIOL_BIT]    = irq_en_q.viol;
            end
            default:       bus_rdata = '0;
        endcase
    end

    AST_NEVER_SILENT: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_flags.alarm) |-> ($past(alm_sec_q) != {SEC_W{1'b1}})); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (irq_en_q != '0)); // R9

endmodule

// File: tb/rtc_seconds_alarm_bench.sv
module rtc_seconds_alarm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int FW = 4;
    localparam int CW = SW + FW;
    localparam int CMASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_viol = 1'b0;
    logic        irq;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    rtc_seconds_alarm #(.SEC_W(SW), .FRAC_W(FW)) u_rtc_seconds_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sec_viol  (sec_viol),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, output int edge_no);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        edge_no = cyc;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(output int c);
        logic [31:0] s, f;
        rd(5'h00, s);
        rd(5'h04, f);
        c = int'((s << FW) | f);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int e0, eb, ew, c, fr, expc, seen;
        int starts[6];
        int lens[3];
        starts = '{0, 12'h00F, 12'h0FE, 12'h7F9, 12'hFF0, 12'hFFB};
        lens   = '{0, 3, 21};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset values
        rd(5'h00, v); chk("R10 time sec reset", v, 0);
        rd(5'h04, v); chk("R10 time frac reset", v, 0);
        rd(5'h08, v); chk("R6 alarm sec reset all ones", v, 32'hFF);
        rd(5'h0C, v); chk("R10 alarm frac reset", v, 0);
        rd(5'h10, v); chk("R10 ctrl reset", v, 0);
        rd(5'h14, v); chk("R8 status reset not-valid", v, 32'h02);
        rd(5'h18, v); chk("R10 enable reset", v, 0);
        rd(5'h1C, v); chk("R10 unmapped reads zero", v, 0);
        chk("R9 irq low after reset", irq, 0);

        // R3 no counting before seconds write
        wr(5'h10, 32'h8, e0);
        idle(6);
        rd_cnt(c); chk("R3 unseeded holds", c, 0);
        wr(5'h04, 32'h5, e0);
        idle(6);
        rd_cnt(c); chk("R3 frac write loads but no count", c, 32'h005);
        wr(5'h00, 32'h10, e0);
        idle(7);
        wr(5'h10, 32'h0, eb);
        rd_cnt(c); chk("R3 seeding starts count", c, (32'h105 + eb - e0 + 1) & CMASK);
        idle(10);
        rd_cnt(expc);
        chk("R2 halted counter stable", expc, c);

        // R1/R2 sweep of starts and run lengths
        foreach (starts[i]) begin
            foreach (lens[j]) begin
                wr(5'h00, starts[i] >> FW, e0);
                wr(5'h04, starts[i] & 15, e0);
                wr(5'h10, 32'h8, e0);
                idle(lens[j]);
                wr(5'h10, 32'h0, eb);
                rd_cnt(c);
                chk("R1 R2 run window count", c, (starts[i] + eb - e0) & CMASK);
            end
        end

        // R4 field-only write while halted
        wr(5'h00, 32'h22, e0);
        wr(5'h04, 32'h7, e0);
        wr(5'h00, 32'h33, e0);
        rd_cnt(c); chk("R4 sec write keeps frac", c, 32'h337);
        wr(5'h04, 32'hC, e0);
        rd_cnt(c); chk("R4 frac write keeps sec", c, 32'h33C);

        // R4 write during counting wins over increment
        wr(5'h00, 32'h20, e0);
        wr(5'h04, 32'h3, e0);
        wr(5'h10, 32'h8, e0);
        idle(3);
        wr(5'h00, 32'h40, ew);
        idle(2);
        wr(5'h10, 32'h0, eb);
        rd_cnt(c);
        fr = (3 + ew - e0 - 2) & 15;
        chk("R4 write beats increment", c, ((32'h40 << FW) + fr + eb - ew + 1) & CMASK);

        // R5 alarm timing and stickiness
        wr(5'h14, 32'h10, e0);
        wr(5'h00, 32'h30, e0);
        wr(5'h04, 32'h0, e0);
        wr(5'h0C, 32'h8, e0);
        wr(5'h08, 32'h30, e0);
        wr(5'h18, 32'h10, e0);
        rd(5'h14, v); chk("R5 no alarm before match", v & 32'h10, 0);
        wr(5'h10, 32'h8, e0);
        seen = -1;
        for (int k = 0; k < 40; k++) begin
            rd(5'h14, v);
            if (v[4] && seen < 0) seen = cyc - e0;
        end
        chk("R5 alarm sets one edge after match", seen, 10);
        chk("R9 irq follows enabled alarm", irq, 1);
        wr(5'h10, 32'h0, eb);
        rd(5'h14, v); chk("R5 alarm sticky past match", v, 32'h12);
        wr(5'h14, 32'h0, e0);
        rd(5'h14, v); chk("R7 writing zero leaves flags", v, 32'h12);
        wr(5'h14, 32'h10, e0);
        rd(5'h14, v); chk("R7 write one clears alarm", v, 32'h02);
        chk("R9 irq drops when flag clears", irq, 0);

        // R7 set and clear in the same cycle
        wr(5'h04, 32'h8, e0);
        wr(5'h00, 32'h30, e0);
        rd(5'h14, v); chk("R5 alarm on halted match", v & 32'h10, 32'h10);
        wr(5'h14, 32'h10, e0);
        rd(5'h14, v); chk("R7 set wins over clear", v & 32'h10, 32'h10);
        wr(5'h0C, 32'h9, e0);
        wr(5'h14, 32'h10, e0);
        rd(5'h14, v); chk("R7 clear after match removed", v & 32'h10, 0);

        // R6 never value
        wr(5'h08, 32'hFF, e0);
        wr(5'h0C, 32'h2, e0);
        wr(5'h00, 32'hFF, e0);
        wr(5'h04, 32'h2, e0);
        idle(3);
        rd(5'h14, v); chk("R6 all-ones seconds never matches halted", v & 32'h10, 0);
        wr(5'h04, 32'h0, e0);
        wr(5'h10, 32'h8, e0);
        idle(20);
        wr(5'h10, 32'h0, eb);
        rd(5'h14, v); chk("R6 all-ones seconds never matches running", v & 32'h10, 0);
        rd_cnt(c); chk("R1 wrap through all ones", c, (32'hFF0 + eb - e0) & CMASK);

        // R8 violation flag and R9 enables
        wr(5'h18, 32'h01, e0);
        chk("R9 irq low with viol enabled but clear", irq, 0);
        @(negedge clk); sec_viol = 1'b1;
        @(negedge clk); sec_viol = 1'b0;
        rd(5'h14, v); chk("R8 violation flag set", v, 32'h03);
        chk("R9 irq from violation", irq, 1);
        wr(5'h18, 32'h10, e0);
        chk("R9 irq masked when enable off", irq, 0);
        wr(5'h18, 32'h02, e0);
        chk("R9 irq from not-valid flag", irq, 1);
        wr(5'h14, 32'h13, e0);
        rd(5'h14, v); chk("R7 R8 clear all flags", v, 32'h00);
        chk("R9 irq low after clear", irq, 0);
        idle(4);
        rd(5'h14, v); chk("R8 not-valid stays cleared", v, 32'h00);

        // R10 unused bits
        wr(5'h18, 32'hFFFF_FFFF, e0);
        rd(5'h18, v); chk("R10 enable unused bits zero", v, 32'h13);
        wr(5'h0C, 32'hFFFF, e0);
        rd(5'h0C, v); chk("R10 alarm frac width", v, 32'hF);
        wr(5'h04, 32'hFFFF, e0);
        rd(5'h04, v); chk("R4 R10 time frac width", v, 32'hF);
        wr(5'h10, 32'hFFFF_FFFF, e0);
        rd(5'h10, v); chk("R2 R10 ctrl only run bit", v, 32'h08);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule